// File: doc/BRIEF.md
# Multi-Channel Match-Compare Timer

This block is a bank of independent up-counting timers. Each timer has several match comparators and sits behind a simple register port made of an address, write data, a write strobe and combinational read data. Every timer runs a two-state controller. In `TS_HALT` the counter is held at zero. In `TS_COUNT` it advances by one on each cycle where the shared `tick` input is high. The transition `TS_HALT -> TS_COUNT` ("start") happens on a write to the global run register with the timer's bit set. The transition `TS_COUNT -> TS_HALT` ("stop") happens on a write with the bit clear, and clears the counter in that same edge.

A comparator fires on a counting tick in which the counter equals its match value. The hit sets a sticky status bit, whether or not its interrupt is enabled. Each timer drives one interrupt line, which is high while any status bit is set together with its enable bit. A timer in periodic mode restarts from zero on a comparator 0 hit. A timer in free-running mode wraps modulo 2^CNT_W. To get an event after N ticks, software loads N-1 into comparator 0.

Top module: `match_timer_bank`

## Requirements
- R1: After reset every readable register reads zero, all timers are in `TS_HALT`, and all interrupt lines are low.
- R2: Address 0 is the run register, and bit t controls timer t. Writing a 0 bit stops that timer and leaves its counter at zero. Writing a 1 to an already running timer does not restart it. Writing 0x2 stops timer 0 and leaves timer 1 counting.
- R3: A running counter advances by exactly one on a cycle with `tick` high. It holds its value while `tick` is low.
- R4: Comparator c sets status bit c on the tick in which the counter equals match c. With match 0 loaded with N-1, the bit is set exactly after the N-th tick since start.
- R5: With mode bit 0 at 1 (periodic), a comparator 0 hit loads zero into the counter instead of incrementing it.
- R6: With mode bit 0 at 0 (free-running), the counter wraps from 2^CNT_W-1 to 0, and comparator 0 does not restart it.
- R7: Writing the status register clears exactly the bits written as 1 (bit c is comparator c). All other bits are kept.
- R8: When a hit and a clear of the same status bit happen in the same cycle, the bit ends set.
- R9: `irq[t]` is the OR over c of (status bit c AND enable bit c). An enable register of zero masks every hit, while the status bits are still recorded.
- R10: Timer t occupies word addresses 8*(t+1)+k. For k = 0, 1, 2, 3..5 and 6 these are mode, interrupt enable, status, match 0..2 and counter value. Mode, enable and match read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable, one cycle per tick |
| addr | input | ADDR_W | Word address |
| wdata | input | CNT_W | Write data |
| wr_en | input | 1 | Write strobe |
| rdata | output | CNT_W | Read data for `addr` (combinational) |
| irq | output | NUM_TMR | Per-timer interrupt line |

## Verification
The bench builds the block with three timers of three comparators each and an 8-bit counter width. The narrow counter brings the free-running wrap of R6 within a few hundred ticks. The bench sweeps the periodic period N from 1 to 12 and checks, for each N, the status before and after the N-th tick and the restart value. It also lines up a status clear with a comparator hit in the same edge to exercise R8, and runs two timers side by side to show that the run bits act independently.

// File: rtl/mtb_pkg.sv
`timescale 1ns/1ps
package mtb_pkg;
    typedef enum logic {TS_HALT = 1'b0, TS_COUNT = 1'b1} tmr_state_e;

    localparam int unsigned SLOT_BITS = 3;
    localparam int unsigned OFS_MODE  = 0;
    localparam int unsigned OFS_IE    = 1;
    localparam int unsigned OFS_STS   = 2;
    localparam int unsigned OFS_MATCH = 3;
    localparam int unsigned OFS_CNT   = 6;
endpackage

// File: rtl/mtb_cmp.sv
`timescale 1ns/1ps
module mtb_cmp #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_tick_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             wr_match_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] match_o,
    output logic             hit_o,
    output logic             sts_o
);
    logic [CNT_W-1:0] match_q;
    logic             sts_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= '0;
        end else if (wr_match_i) begin
            match_q <= wdata_i;
        end
    end

    assign hit_o = count_tick_i && (cnt_i == match_q);

    // hardware set has priority over a software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= 1'b0;
        end else if (hit_o) begin
            sts_q <= 1'b1;
        end else if (clr_i) begin
            sts_q <= 1'b0;
        end
    end

    assign match_o = match_q;
    assign sts_o   = sts_q;

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_tick_i && cnt_i == match_o && clr_i) |=> sts_o);

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_o && !clr_i) |=> sts_o);
endmodule

// File: rtl/mtb_channel.sv
`timescale 1ns/1ps
module mtb_channel
    import mtb_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned NUM_CMP = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            tick_i,
    input  logic                            en_wr_i,
    input  logic                            en_bit_i,
    input  logic [CNT_W-1:0]                wdata_i,
    input  logic                            wr_mode_i,
    input  logic                            wr_ie_i,
    input  logic                            wr_clr_i,
    input  logic [NUM_CMP-1:0]              wr_match_i,
    output logic                            running_o,
    output logic                            periodic_o,
    output logic [NUM_CMP-1:0]              ie_o,
    output logic [NUM_CMP-1:0]              sts_o,
    output logic [CNT_W-1:0]                cnt_o,
    output logic [NUM_CMP-1:0][CNT_W-1:0]   match_o
);
    tmr_state_e           state_q, state_d;
    logic [CNT_W-1:0]     cnt_q, cnt_d;
    logic                 periodic_q;
    logic [NUM_CMP-1:0]   ie_q;
    logic [NUM_CMP-1:0]   hit;
    logic                 count_tick;
    logic                 stop_req;

    assign stop_req   = en_wr_i && !en_bit_i;
    assign count_tick = (state_q == TS_COUNT) && tick_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TS_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_HALT:  if (en_wr_i && en_bit_i) state_d = TS_COUNT;
            TS_COUNT: if (stop_req)            state_d = TS_HALT;
        endcase
    end

    always_comb begin
        cnt_d = cnt_q;
        unique case (state_q)
            TS_HALT:  cnt_d = '0;
            TS_COUNT: begin
                if (stop_req) begin
                    cnt_d = '0;
                end else if (tick_i) begin
                    cnt_d = (periodic_q && hit[0]) ? '0 : cnt_q + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            periodic_q <= 1'b0;
            ie_q       <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (wr_mode_i) periodic_q <= wdata_i[0];
            if (wr_ie_i)   ie_q       <= wdata_i[NUM_CMP-1:0];
        end
    end

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
        mtb_cmp #(.CNT_W(CNT_W)) u_cmp (
            .clk          (clk),
            .rst_n        (rst_n),
            .count_tick_i (count_tick),
            .cnt_i        (cnt_q),
            .wr_match_i   (wr_match_i[c]),
            .wdata_i      (wdata_i),
            .clr_i        (wr_clr_i && wdata_i[c]),
            .match_o      (match_o[c]),
            .hit_o        (hit[c]),
            .sts_o        (sts_o[c])
        );
    end

    assign running_o  = (state_q == TS_COUNT);
    assign periodic_o = periodic_q;
    assign ie_o       = ie_q;
    assign cnt_o      = cnt_q;

    // R2
    halt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running_o |-> (cnt_o == '0));

    // R5
    periodic_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && tick_i && periodic_o && cnt_o == match_o[0]) |=> (cnt_o == '0));

    // R3
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && tick_i && !stop_req && !(periodic_o && cnt_o == match_o[0]))
        |=> (cnt_o == $past(cnt_o) + 1'b1));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && !tick_i && !stop_req) |=> $stable(cnt_o));
endmodule

// File: rtl/match_timer_bank.sv
`timescale 1ns/1ps
module match_timer_bank
    import mtb_pkg::*;
#(
    parameter int unsigned NUM_TMR = 3,
    parameter int unsigned NUM_CMP = 3,
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CNT_W-1:0]   wdata,
    input  logic               wr_en,
    output logic [CNT_W-1:0]   rdata,
    output logic [NUM_TMR-1:0] irq
);
    localparam int unsigned HI_W = ADDR_W - SLOT_BITS;

    logic [HI_W-1:0]                            hi;
    logic [SLOT_BITS-1:0]                       lo;
    logic                                       glob_wr;
    logic [NUM_TMR-1:0]                         running;
    logic [NUM_TMR-1:0]                         periodic;
    logic [NUM_TMR-1:0][NUM_CMP-1:0]            ie_a;
    logic [NUM_TMR-1:0][NUM_CMP-1:0]            sts_a;
    logic [NUM_TMR-1:0][CNT_W-1:0]              cnt_a;
    logic [NUM_TMR-1:0][NUM_CMP-1:0][CNT_W-1:0] match_a;

    assign hi      = addr[ADDR_W-1:SLOT_BITS];
    assign lo      = addr[SLOT_BITS-1:0];
    assign glob_wr = wr_en && (hi == '0) && (lo == '0);

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        logic               sel;
        logic [NUM_CMP-1:0] wr_match;

        assign sel = wr_en && (hi == HI_W'(t + 1));
        for (genvar c = 0; c < NUM_CMP; c++) begin : g_ms
            assign wr_match[c] = sel && (lo == SLOT_BITS'(OFS_MATCH + c));
        end

        mtb_channel #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (tick),
            .en_wr_i    (glob_wr),
            .en_bit_i   (wdata[t]),
            .wdata_i    (wdata),
            .wr_mode_i  (sel && (lo == SLOT_BITS'(OFS_MODE))),
            .wr_ie_i    (sel && (lo == SLOT_BITS'(OFS_IE))),
            .wr_clr_i   (sel && (lo == SLOT_BITS'(OFS_STS))),
            .wr_match_i (wr_match),
            .running_o  (running[t]),
            .periodic_o (periodic[t]),
            .ie_o       (ie_a[t]),
            .sts_o      (sts_a[t]),
            .cnt_o      (cnt_a[t]),
            .match_o    (match_a[t])
        );

        assign irq[t] = |(sts_a[t] & ie_a[t]);

        // R2
        stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (glob_wr && !wdata[t]) |=> (cnt_a[t] == '0));
    end

    always_comb begin
        rdata = '0;
        if (hi == '0 && lo == '0) begin
            rdata[NUM_TMR-1:0] = running;
        end
        for (int t = 0; t < NUM_TMR; t++) begin
            if (hi == HI_W'(t + 1)) begin
                if (lo == SLOT_BITS'(OFS_MODE)) rdata[0] = periodic[t];
                if (lo == SLOT_BITS'(OFS_IE))   rdata[NUM_CMP-1:0] = ie_a[t];
                if (lo == SLOT_BITS'(OFS_STS))  rdata[NUM_CMP-1:0] = sts_a[t];
                if (lo == SLOT_BITS'(OFS_CNT))  rdata = cnt_a[t];
                for (int c = 0; c < NUM_CMP; c++) begin
                    if (lo == SLOT_BITS'(OFS_MATCH + c)) rdata = match_a[t][c];
                end
            end
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (irq == '0 && running == '0));
endmodule

// File: tb/sim_match_timer_bank.sv
`timescale 1ns/1ps
module sim_match_timer_bank;
    localparam int W = 8, NT = 3, NC = 3, AW = 6;

    logic          clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  rdata;
    logic [NT-1:0] irq;
    int n_chk = 0, n_bad = 0;

    match_timer_bank #(.NUM_TMR(NT), .NUM_CMP(NC), .CNT_W(W), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
        .wdata(wdata), .wr_en(wr_en), .rdata(rdata), .irq(irq));

    always #2.5 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] ra(int t, int off);
        return AW'((t + 1) * 8 + off);
    endfunction

    task automatic wr(logic [AW-1:0] a, int d);
        addr = a; wdata = W'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_tick(logic [AW-1:0] a, int d);
        addr = a; wdata = W'(d); wr_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic tk(int n);
        if (n > 0) begin
            tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, v); chk("R1 run reg", v, 0);
        for (int t = 0; t < NT; t++)
            for (int k = 0; k < 7; k++) begin
                rd(ra(t, k), v); chk("R1 reg", v, 0);
            end
        chk("R1 irq", int'(irq), 0);

        // R10 register readback
        for (int t = 0; t < NT; t++) begin
            for (int c = 0; c < NC; c++) begin
                wr(ra(t, 3 + c), t * 16 + c + 1);
                rd(ra(t, 3 + c), v); chk("R10 match readback", v, t * 16 + c + 1);
            end
            wr(ra(t, 1), 5); rd(ra(t, 1), v); chk("R10 ie readback", v, 5);
            wr(ra(t, 1), 0);
            wr(ra(t, 0), 1); rd(ra(t, 0), v); chk("R10 mode readback", v, 1);
            wr(ra(t, 0), 0);
        end

        // R4 / R5 periodic sweep on timer 0
        wr(ra(0, 0), 1); wr(ra(0, 1), 1);
        for (int n = 1; n <= 12; n++) begin
            wr(ra(0, 3), n - 1);
            wr(ra(0, 2), 7);
            wr(0, 1);
            tk(n - 1);
            rd(ra(0, 6), v); chk("R4 count before event", v, n - 1);
            rd(ra(0, 2), v); chk("R4 no status before Nth tick", v & 1, 0);
            tk(1);
            rd(ra(0, 2), v); chk("R4 status after Nth tick", v & 1, 1);
            chk("R9 irq0 enabled", int'(irq[0]), 1);
            rd(ra(0, 6), v); chk("R5 periodic restart", v, 0);
            wr(0, 0);
            rd(ra(0, 6), v); chk("R2 stopped count zero", v, 0);
            rd(0, v); chk("R2 run reg cleared", v, 0);
        end
        wr(ra(0, 2), 7);

        // R6 free-running wrap on timer 1, interrupt masked
        wr(ra(1, 3), 5); wr(ra(1, 2), 7); wr(ra(1, 1), 0);
        wr(0, 2);
        tk(5);
        rd(ra(1, 2), v); chk("R4 free status before hit", v & 1, 0);
        tk(1);
        rd(ra(1, 2), v); chk("R4 free status after hit", v & 1, 1);
        chk("R9 masked irq1", int'(irq[1]), 0);
        rd(ra(1, 6), v); chk("R6 no restart on match 0", v, 6);
        tk(250);
        rd(ra(1, 6), v); chk("R6 wrap to zero", v, 0);
        tk(3);
        rd(ra(1, 6), v); chk("R6 after wrap", v, 3);

        // R2 independent run bits
        wr(0, 3);
        tk(2);
        rd(ra(1, 6), v); chk("R2 timer1 not restarted", v, 5);
        rd(ra(0, 6), v); chk("R2 timer0 started", v, 2);
        wr(0, 2);
        tk(1);
        rd(ra(0, 6), v); chk("R2 timer0 stopped by 0x2", v, 0);
        rd(ra(1, 6), v); chk("R2 timer1 still runs", v, 6);
        rd(0, v); chk("R2 run reg", v, 2);

        // R3 tick low holds the counter
        repeat (5) @(negedge clk);
        rd(ra(1, 6), v); chk("R3 hold without tick", v, 6);

        // R9 enabling and masking the interrupt
        wr(ra(1, 1), 1); chk("R9 irq1 enabled", int'(irq[1]), 1);
        wr(ra(1, 1), 0); chk("R9 irq1 masked", int'(irq[1]), 0);
        wr(0, 0);

        // R4 / R7 / R9 three comparators on timer 2
        wr(ra(2, 3), 3); wr(ra(2, 4), 5); wr(ra(2, 5), 7);
        wr(ra(2, 2), 7); wr(ra(2, 1), 2);
        wr(0, 4);
        tk(4);
        rd(ra(2, 2), v); chk("R4 cmp0 only", v, 1);
        chk("R9 cmp0 not enabled", int'(irq[2]), 0);
        tk(2);
        rd(ra(2, 2), v); chk("R4 cmp0 and cmp1", v, 3);
        chk("R9 cmp1 enabled", int'(irq[2]), 1);
        tk(2);
        rd(ra(2, 2), v); chk("R4 all three", v, 7);
        wr(ra(2, 2), 1);
        rd(ra(2, 2), v); chk("R7 clear bit0 only", v, 6);
        wr(ra(2, 2), 2);
        rd(ra(2, 2), v); chk("R7 clear bit1 only", v, 4);
        chk("R9 irq2 drops", int'(irq[2]), 0);

        // R8 set wins over a simultaneous clear
        rd(ra(2, 6), v2); chk("R8 setup count", v2, 8);
        wr(ra(2, 4), 8);
        wr_tick(ra(2, 2), 2);
        rd(ra(2, 2), v); chk("R8 set wins", v, 6);
        chk("R8 irq2 on", int'(irq[2]), 1);
        wr(ra(2, 2), 2);
        rd(ra(2, 2), v); chk("R7 later clear", v, 4);
        rd(ra(2, 6), v); chk("R3 one tick counted", v, 9);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule